// File: doc/BRIEF.md
# Channel Overcurrent and Undervoltage Fault Guard

This block supervises one channel of a step-down regulator. It watches a peak-current flag, an output-undervoltage flag and a softstart-complete flag, and it decides when the channel's PWM may switch. It also decides when a PWM cycle must be cut short, when whole cycles must be skipped, and when the channel must rest before it tries again. It sits between the analog comparators and the PWM engine. A PWM cycle-start strobe and a slow time tick are its only timing references.

During softstart, an overcurrent kills the running cycle and blanks the next `SKIP_CYCLES` cycle starts. In steady state, an overcurrent only truncates the cycle in which it is seen. Two events stop switching and start a timed rest of `REST_TICKS` ticks, after which softstart is requested again: a softstart that fails to finish within `2*SS_TICKS` ticks, and an undervoltage in steady state. When the channel is linked to its neighbour, a rest caused by the neighbour's own fault also stops this channel.

Top module: `chan_fault_guard`

## Requirements
- R1: After reset, and while `run_i` is low, `pwm_en_o`, `kill_o`, `fault_o`, `trip_o` and `ss_restart_o` are all 0.
- R2: One clock after `run_i` is sampled high in the idle state, `pwm_en_o` becomes 1 and `ss_restart_o` is 1 for exactly that one clock.
- R3: In softstart, `oc_i` drives `kill_o` high in the same clock. `kill_o` then stays high through the remainder of that PWM cycle and through the next `SKIP_CYCLES` (default 7) cycle starts. It falls at the edge that samples the `SKIP_CYCLES+1`-th `cyc_start_i` pulse.
- R4: In steady state, `kill_o` follows `oc_i` combinationally, and nothing carries over into later cycles.
- R5: In steady state, the clock after `uv_i` is sampled high, `pwm_en_o` is 0 and `trip_o` pulses high for one clock. `uv_i` has no effect during softstart.
- R6: A rest keeps `pwm_en_o` at 0 for exactly `REST_TICKS` `tick_i` pulses. The edge that samples the last of these pulses re-enters softstart, with `pwm_en_o`=1 and an `ss_restart_o` pulse.
- R7: If `ss_done_i` is not seen within `2*SS_TICKS` ticks of entering softstart, the channel rests and `trip_o` pulses. `ss_done_i` seen earlier moves the channel to steady state.
- R8: `fault_o` is high during a rest, during a softstart skip window, and in any clock where `oc_i` is high while switching.
- R9: With `link_en_i` high, `peer_trip_i` moves a switching channel into rest without a `trip_o` pulse. With `link_en_i` low, `peer_trip_i` is ignored.
- R10: `run_i` low returns the channel to idle on the next clock from any state. Switching resumes only through a fresh softstart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel on request |
| oc_i | input | 1 | Peak current over limit, sampled every clock |
| uv_i | input | 1 | Output below undervoltage threshold (comparator has hysteresis) |
| ss_done_i | input | 1 | Softstart ramp finished |
| cyc_start_i | input | 1 | One-clock strobe at each PWM cycle start |
| tick_i | input | 1 | One-clock time base strobe |
| link_en_i | input | 1 | Share shutdown with the other channel |
| peer_trip_i | input | 1 | Other channel tripped on its own fault |
| pwm_en_o | output | 1 | PWM switching allowed |
| kill_o | output | 1 | Terminate or blank the current PWM cycle |
| ss_restart_o | output | 1 | One-clock request to restart the softstart ramp |
| fault_o | output | 1 | Channel status not good |
| trip_o | output | 1 | One-clock pulse on entering rest from an own fault |

## Verification
The result of `kill_o` for an overcurrent is due in the same clock. The bench therefore drives `oc_i` 2 ns after an edge and reads `kill_o` 1 ns later, before any further edge. Every state-driven result (`pwm_en_o`, `trip_o`, `ss_restart_o`, the end of a skip window) is due one clock after the strobe that causes it. Each such strobe is held for exactly one edge, and the output is read 2 ns after that edge. Tick and cycle-start counts are swept one pulse at a time, so the bench checks that the output has not moved before the final pulse and has moved right after it.

// File: rtl/chan_fault_guard.sv
module chan_fault_guard #(
  parameter int SKIP_CYCLES = 7,
  parameter int SS_TICKS    = 8,
  parameter int REST_TICKS  = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic oc_i,
  input  logic uv_i,
  input  logic ss_done_i,
  input  logic cyc_start_i,
  input  logic tick_i,
  input  logic link_en_i,
  input  logic peer_trip_i,
  output logic pwm_en_o,
  output logic kill_o,
  output logic ss_restart_o,
  output logic fault_o,
  output logic trip_o
);

  localparam int SS_LIMIT = 2 * SS_TICKS;
  localparam int TMAX     = (SS_LIMIT > REST_TICKS) ? SS_LIMIT : REST_TICKS;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int SKW      = $clog2(SKIP_CYCLES + 2);
  localparam logic [SKW-1:0] SKIP_LOAD = SKW'(SKIP_CYCLES + 1);
  localparam logic [TW-1:0]  SS_LAST   = TW'(SS_LIMIT - 1);
  localparam logic [TW-1:0]  REST_LAST = TW'(REST_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SOFT, S_RUN, S_REST} st_t;

  st_t            st, st_n;
  logic [TW-1:0]  tmr;
  logic [SKW-1:0] skip;
  logic           own_trip;

  wire switching = (st == S_SOFT) || (st == S_RUN);
  wire peer_hit  = link_en_i && peer_trip_i;
  wire ss_expire = tick_i && (tmr == SS_LAST);
  wire rest_done = tick_i && (tmr == REST_LAST);

  always_comb begin
    st_n     = st;
    own_trip = 1'b0;
    case (st)
      S_IDLE: if (run_i) st_n = S_SOFT;
      S_SOFT: begin
        if (!run_i)         st_n = S_IDLE;
        else if (peer_hit)  st_n = S_REST;
        else if (ss_done_i) st_n = S_RUN;
        else if (ss_expire) begin
          st_n     = S_REST;
          own_trip = 1'b1;
        end
      end
      S_RUN: begin
        if (!run_i)        st_n = S_IDLE;
        else if (peer_hit) st_n = S_REST;
        else if (uv_i) begin
          st_n     = S_REST;
          own_trip = 1'b1;
        end
      end
      S_REST: begin
        if (!run_i)         st_n = S_IDLE;
        else if (rest_done) st_n = S_SOFT;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      skip         <= '0;
      trip_o       <= 1'b0;
      ss_restart_o <= 1'b0;
    end else begin
      st           <= st_n;
      trip_o       <= own_trip;
      ss_restart_o <= (st_n == S_SOFT) && (st != S_SOFT);
      if (st_n != st)
        tmr <= '0;
      else if (tick_i && (st == S_SOFT || st == S_REST))
        tmr <= tmr + 1'b1;
      if (st_n != S_SOFT)
        skip <= '0;
      else if (oc_i && st == S_SOFT)
        skip <= SKIP_LOAD;
      else if (cyc_start_i && skip != '0)
        skip <= skip - 1'b1;
    end
  end

  assign pwm_en_o = switching;
  assign kill_o   = (switching && oc_i) || (skip != '0);
  assign fault_o  = (st == S_REST) || kill_o;

  // R4
  oc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en_o && oc_i) |-> kill_o);

  // R3
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFT && st_n == S_SOFT && skip != '0 && !cyc_start_i) |=> kill_o);

  // R5
  uv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && run_i && !peer_hit && uv_i) |=> (!pwm_en_o && trip_o));

  // R7
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> !pwm_en_o);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en_o) |-> ss_restart_o);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pwm_en_o);

endmodule

// File: tb/chan_fault_guard_tb.sv
module chan_fault_guard_tb;
  localparam int SKIP = 7;
  localparam int SST  = 3;
  localparam int REST = 5;

  logic clk = 1'b0;
  logic rst_n, run_i, oc_i, uv_i, ss_done_i, cyc_start_i, tick_i, link_en_i, peer_trip_i;
  logic pwm_en_o, kill_o, ss_restart_o, fault_o, trip_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_fault_guard #(.SKIP_CYCLES(SKIP), .SS_TICKS(SST), .REST_TICKS(REST)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .oc_i(oc_i), .uv_i(uv_i),
    .ss_done_i(ss_done_i), .cyc_start_i(cyc_start_i), .tick_i(tick_i),
    .link_en_i(link_en_i), .peer_trip_i(peer_trip_i), .pwm_en_o(pwm_en_o),
    .kill_o(kill_o), .ss_restart_o(ss_restart_o), .fault_o(fault_o), .trip_o(trip_o));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic tick_pulse();
    tick_i = 1'b1; step(); tick_i = 1'b0;
  endtask

  task automatic rest_out();
    for (int k = 1; k <= REST; k++) begin
      tick_pulse();
      chk(pwm_en_o, k == REST, "R6 rest length");
      chk(ss_restart_o, k == REST, "R6 restart request");
    end
  endtask

  task automatic to_run();
    ss_done_i = 1'b1; step(); ss_done_i = 1'b0;
    chk(pwm_en_o, 1'b1, "R7 softstart done keeps switching");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run_i = 0; oc_i = 0; uv_i = 0; ss_done_i = 0;
    cyc_start_i = 0; tick_i = 0; link_en_i = 0; peer_trip_i = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset and idle
    for (int i = 0; i < 3; i++) begin
      chk(pwm_en_o, 1'b0, "R1 pwm_en idle");
      chk(kill_o, 1'b0, "R1 kill idle");
      chk(fault_o, 1'b0, "R1 fault idle");
      chk(trip_o, 1'b0, "R1 trip idle");
      chk(ss_restart_o, 1'b0, "R1 restart idle");
      step();
    end
    // R2 start
    run_i = 1'b1; step();
    chk(pwm_en_o, 1'b1, "R2 start pwm_en");
    chk(ss_restart_o, 1'b1, "R2 restart pulse");
    step();
    chk(ss_restart_o, 1'b0, "R2 restart one clock");
    // R3 skip window in softstart
    oc_i = 1'b1; #1;
    chk(kill_o, 1'b1, "R3 same-clock kill");
    chk(fault_o, 1'b1, "R8 fault on oc");
    step(); oc_i = 1'b0; #1;
    chk(kill_o, 1'b1, "R3 kill held");
    for (int k = 1; k <= SKIP + 1; k++) begin
      cyc_start_i = 1'b1; step(); cyc_start_i = 1'b0; #1;
      chk(kill_o, k <= SKIP, "R3 skipped cycle");
      chk(fault_o, k <= SKIP, "R8 fault in skip window");
    end
    // R5 uv ignored in softstart
    uv_i = 1'b1; step(); uv_i = 1'b0;
    chk(pwm_en_o, 1'b1, "R5 uv ignored in softstart");
    chk(trip_o, 1'b0, "R5 no trip in softstart");
    // R7 softstart timeout after 2*SST ticks
    for (int k = 1; k <= 2 * SST; k++) begin
      tick_pulse();
      chk(pwm_en_o, k < 2 * SST, "R7 timeout point");
      chk(trip_o, k == 2 * SST, "R7 trip on timeout");
    end
    chk(fault_o, 1'b1, "R8 fault in rest");
    step();
    chk(trip_o, 1'b0, "R7 trip one clock");
    oc_i = 1'b1; #1;
    chk(kill_o, 1'b0, "R8 no kill while resting");
    oc_i = 1'b0;
    rest_out();
    to_run();
    for (int k = 0; k < 2 * SST + 2; k++) tick_pulse();
    chk(pwm_en_o, 1'b1, "R7 no timeout in steady state");
    // R4 cycle-by-cycle in steady state
    for (int i = 0; i < 12; i++) begin
      oc_i = ((12'b1011_0010_0110 >> i) & 1) != 0;
      cyc_start_i = (i % 3) == 0;
      #1;
      chk(kill_o, oc_i, "R4 kill follows oc");
      chk(fault_o, oc_i, "R8 fault follows oc");
      step();
    end
    oc_i = 1'b0; cyc_start_i = 1'b0; #1;
    chk(kill_o, 1'b0, "R4 no carry-over");
    // R9 linked shutdown
    peer_trip_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(pwm_en_o, 1'b1, "R9 peer ignored unlinked");
    end
    link_en_i = 1'b1; step(); link_en_i = 1'b0; peer_trip_i = 1'b0;
    chk(pwm_en_o, 1'b0, "R9 peer stops channel");
    chk(trip_o, 1'b0, "R9 no own trip");
    chk(fault_o, 1'b1, "R9 fault in rest");
    rest_out();
    to_run();
    // R5 uv in steady state
    uv_i = 1'b1; step(); uv_i = 1'b0;
    chk(pwm_en_o, 1'b0, "R5 uv stops pwm");
    chk(trip_o, 1'b1, "R5 uv trip");
    step();
    chk(trip_o, 1'b0, "R5 trip one clock");
    // R10 run low from rest
    run_i = 1'b0; step();
    chk(pwm_en_o, 1'b0, "R10 idle");
    chk(fault_o, 1'b0, "R10 fault clear in idle");
    for (int k = 0; k < REST + 2; k++) tick_pulse();
    chk(pwm_en_o, 1'b0, "R10 no restart while off");
    run_i = 1'b1; step();
    chk(ss_restart_o, 1'b1, "R10 restart via softstart");
    to_run();
    run_i = 1'b0; step();
    chk(pwm_en_o, 1'b0, "R10 idle from steady state");
    chk(ss_restart_o, 1'b0, "R1 no restart while off");
    finish_run();
  end
endmodule